// File: doc/BRIEF.md
# APB Reloading Down-Counter Timer

This block is a single-channel 32-bit down-counter placed behind an APB slave port. Software sets a start count and a reload count, then turns the timer on. From then on the counter steps down by one on each count tick. When it reaches zero it stays there for one more tick and then takes the reload count and carries on. The step from 1 to 0 can latch an interrupt status bit, and that bit drives a level interrupt line until software clears it by writing a 1.

By default a count tick is every bus clock while the timer is enabled. An external input can limit counting to the times when it is high. It can also replace the bus clock as the tick source, so that each rising edge gives one tick. The input is resynchronised through two flops before use. A read-only identification area sits at the top of the 4 KB window.

Top module: `apb_down_timer`

## Requirements
- R1: After reset, control (0x0), value (0x4), reload (0x8) and status (0xC) all read 0 and `irq` is low.
- R2: Control is 4 bits wide: bit 0 run, bit 1 count only while the external input is high, bit 2 count on external rising edges, bit 3 interrupt enable. Bits above 3 are discarded on write and read back as 0.
- R3: When bit 0 is set and bits 1 and 2 are clear, a nonzero count drops by exactly one on every clock edge.
- R4: On a tick that moves the count from 1 to 0, status bit 0 is set if control bit 3 is 1. If control bit 3 is 0, status is left unchanged. `irq` equals status bit 0.
- R5: A tick while the count is 0 loads the reload value. After expiry the count therefore spends one tick at 0 before reloading.
- R6: With a reload value of 0, a count at 0 stays at 0 and no further interrupt is raised.
- R7: Writing the reload register sets both the reload value and the current count. Writing the value register changes only the current count.
- R8: Writing 1 to status bit 0 clears it and lowers `irq`. Writing 0 leaves it unchanged.
- R9: Word offsets 0xFD0 through 0xFFC read the fixed bytes 04,00,00,00,22,B8,1B,00,0D,F0,05,B1 in ascending address order. Writes there have no effect.
- R10: Unmapped offsets read 0 and ignore writes. `pready` is always 1 and `pslverr` is always 0.
- R11: With control bits 1:0 set to 11b, the counter steps once per clock for each clock the synchronised input is high, and it holds while the input is low.
- R12: With control bit 2 set, each synchronised rising edge of the external input gives one tick. A held-high input gives only one tick. With bits 1 and 2 both set, the behaviour is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered in the setup phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 1 | External enable or tick input, asynchronous |
| irq | output | 1 | Level interrupt, equals status bit 0 |

## Verification
A register write takes effect on the clock edge that ends its access phase. Read data is captured on the edge that ends the setup phase and is sampled mid access phase. Status and `irq` rise one edge after the tick on which the count goes from 1 to 0. An external edge reaches the counter three edges after the input changes.

The bench does not try to catch these latencies at the exact cycle. Instead it counts how many ticks fall inside a window fixed by two control writes. Both writes land on known edges, and both edges of the stopping write still tick. It then stops the timer and reads the count back. A step-by-step arithmetic model, run over a sweep of start, reload and window lengths, predicts the count and the interrupt for each case.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_VALUE  = 1;
  localparam int REG_RELOAD = 2;
  localparam int REG_STAT   = 3;
  localparam int ID_WORDS   = 12;

  typedef struct packed {
    logic irq_en;
    logic ext_clk;
    logic ext_gate;
    logic run;
  } ctrl_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:  id_byte = 8'h04;
      4'd4:  id_byte = 8'h22;
      4'd5:  id_byte = 8'hB8;
      4'd6:  id_byte = 8'h1B;
      4'd8:  id_byte = 8'h0D;
      4'd9:  id_byte = 8'hF0;
      4'd10: id_byte = 8'h05;
      4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic at_zero;
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (load_en)
      count <= load_val;
    else if (tick)
      count <= at_zero ? reload : count - CNT_W'(1);
  end

  assign expire = tick & ~load_en & (count == CNT_W'(1));
endmodule

// File: rtl/apb_down_timer.sv
module apb_down_timer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_in,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int IDX_W   = ADDR_W - 2;
  localparam int ID_BASE = (1 << IDX_W) - ID_WORDS;

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  reload;
  logic              status;
  logic [CNT_W-1:0]  count;
  logic              expire;
  logic              ext_level, ext_rise;
  logic              tick;
  logic [IDX_W-1:0]  idx;
  logic              wr, rd_setup, load_en, stat_clr, in_id;
  logic [DATA_W-1:0] rd_mux;
  logic [IDX_W-1:0]  id_off;

  assign idx      = paddr[ADDR_W-1:2];
  assign wr       = psel & penable & pwrite;
  assign rd_setup = psel & ~penable;
  assign load_en  = wr & ((idx == IDX_W'(REG_VALUE)) | (idx == IDX_W'(REG_RELOAD)));
  assign stat_clr = wr & (idx == IDX_W'(REG_STAT)) & pwdata[0];
  assign in_id    = (idx >= IDX_W'(ID_BASE));
  assign id_off   = idx - IDX_W'(ID_BASE);

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_in),
    .level(ext_level), .rise(ext_rise)
  );

  assign tick = ctrl.run & (~ctrl.ext_gate | ext_level) & (~ctrl.ext_clk | ext_rise);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
    .load_val(pwdata[CNT_W-1:0]), .reload(reload),
    .count(count), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
      status <= 1'b0;
    end else begin
      if (wr && idx == IDX_W'(REG_CTRL))
        ctrl <= ctrl_t'(pwdata[3:0]);
      if (wr && idx == IDX_W'(REG_RELOAD))
        reload <= pwdata[CNT_W-1:0];
      if (expire && ctrl.irq_en)
        status <= 1'b1;
      else if (stat_clr)
        status <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_id)
      rd_mux = DATA_W'(id_byte(id_off[3:0]));
    else
      case (idx)
        IDX_W'(REG_CTRL):   rd_mux = DATA_W'(ctrl);
        IDX_W'(REG_VALUE):  rd_mux = DATA_W'(count);
        IDX_W'(REG_RELOAD): rd_mux = DATA_W'(reload);
        IDX_W'(REG_STAT):   rd_mux = DATA_W'(status);
        default:            rd_mux = '0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      prdata <= '0;
    else if (rd_setup)
      prdata <= rd_mux;
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq     = status;
endmodule

// File: rtl/apb_down_timer_chk.sv
module apb_down_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             pready,
  input logic             pslverr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             tick,
  input logic             load_en,
  input logic             stat_clr,
  input logic [3:0]       ctrl
);
  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_en && count != '0) |=> count == $past(count) - CNT_W'(1));
  // R5
  reload_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_en && count == '0) |=> count == $past(reload));
  // R6
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && count == '0 && reload == '0) |=> count == '0);
  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(count) == CNT_W'(1) && $past(ctrl[3]) && $past(tick)));
  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(stat_clr));
  // R10
  bus_resp_chk: assert property (@(posedge clk) disable iff (rst)
    pready && !pslverr);
endmodule

bind apb_down_timer apb_down_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .pready(pready), .pslverr(pslverr),
  .count(count), .reload(reload), .tick(tick), .load_en(load_en),
  .stat_clr(stat_clr), .ctrl(ctrl)
);

// File: tb/sim_apb_down_timer.sv
module sim_apb_down_timer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        psel = 0, penable = 0, pwrite = 0, ext_in = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;
  int          checks = 0, errors = 0;
  logic [31:0] rv;

  always #(PERIOD/2) clk = ~clk;

  apb_down_timer u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ext_in(ext_in), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; the second edge passed is the access edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    check("R10 pready", {31'd0, pready}, 32'd1);
    check("R10 pslverr", {31'd0, pslverr}, 32'd0);
    d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] idb [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h22, 8'hB8,
                            8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    int starts [4] = '{0, 1, 2, 5};
    int reloads [3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(12'h000, rv); check("R1 ctrl", rv, 0);
    rd(12'h004, rv); check("R1 value", rv, 0);
    rd(12'h008, rv); check("R1 reload", rv, 0);
    rd(12'h00C, rv); check("R1 status", rv, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R2 upper control bits dropped
    wr(12'h000, 32'hFFFF_FFF4); rd(12'h000, rv); check("R2 ctrl mask", rv, 32'h4);
    wr(12'h000, 32'h0);

    // R7 reload write loads count; value write only count
    wr(12'h008, 32'h55);
    rd(12'h004, rv); check("R7 value after reload", rv, 32'h55);
    rd(12'h008, rv); check("R7 reload", rv, 32'h55);
    wr(12'h004, 32'h22);
    rd(12'h004, rv); check("R7 value", rv, 32'h22);
    rd(12'h008, rv); check("R7 reload kept", rv, 32'h55);

    // R3 free-running decrement: ticks = n + 2
    for (int n = 0; n < 6; n++) begin
      wr(12'h004, 32'd1000); wr(12'h000, 32'h1); idle(n); wr(12'h000, 32'h0);
      rd(12'h004, rv); check("R3 decrement", rv, 32'(1000 - n - 2));
    end

    // R4 R5 R6 sweep against an arithmetic model
    foreach (starts[si]) foreach (reloads[ri]) for (int n = 0; n < 9; n++) begin
      int c, fires;
      c = starts[si]; fires = 0;
      for (int t = 0; t < n + 2; t++) begin
        if (c == 0) c = reloads[ri];
        else begin if (c == 1) fires++; c--; end
      end
      wr(12'h008, 32'(reloads[ri])); wr(12'h004, 32'(starts[si]));
      wr(12'h000, 32'h9); idle(n); wr(12'h000, 32'h8);
      rd(12'h004, rv); check("R5 R6 count model", rv, 32'(c));
      rd(12'h00C, rv); check("R4 status", rv, (fires > 0) ? 1 : 0);
      check("R4 irq level", {31'd0, irq}, (fires > 0) ? 1 : 0);
      wr(12'h00C, 32'h1);
      check("R8 cleared", {31'd0, irq}, 0);
    end

    // R4 no set when interrupt enable is 0
    wr(12'h008, 32'h0); wr(12'h004, 32'd3); wr(12'h000, 32'h1); idle(8); wr(12'h000, 32'h0);
    rd(12'h004, rv); check("R6 stays zero", rv, 0);
    rd(12'h00C, rv); check("R4 no irq_en", rv, 0);

    // R8 write 0 keeps status
    wr(12'h004, 32'd1); wr(12'h000, 32'h9); idle(2); wr(12'h000, 32'h0);
    wr(12'h00C, 32'h0); rd(12'h00C, rv); check("R8 write0 keeps", rv, 1);
    wr(12'h00C, 32'h1); rd(12'h00C, rv); check("R8 w1c", rv, 0);

    // R9 ID bytes and ignored writes
    for (int k = 0; k < 12; k++) begin
      rd(12'hFD0 + 12'(k * 4), rv); check("R9 id", rv, {24'd0, idb[k]});
    end
    wr(12'hFE0, 32'hFFFF_FFFF); rd(12'hFE0, rv); check("R9 id write ignored", rv, 32'h22);

    // R10 unmapped
    rd(12'h010, rv); check("R10 unmapped read", rv, 0);
    rd(12'h800, rv); check("R10 unmapped read hi", rv, 0);
    wr(12'h010, 32'hF); rd(12'h000, rv); check("R10 write ignored", rv, 0);

    // R11 external gate: H high cycles give H ticks
    wr(12'h004, 32'd1000); wr(12'h000, 32'h3);
    idle(10);
    ext_in = 1; idle(7); ext_in = 0; idle(6);
    wr(12'h000, 32'h0);
    rd(12'h004, rv); check("R11 gated count", rv, 32'd993);

    // R12 external clock, alone and with gate
    for (int m = 0; m < 2; m++) begin
      wr(12'h004, 32'd500); wr(12'h000, m ? 32'h7 : 32'h5);
      for (int p = 0; p < 4; p++) begin ext_in = 1; idle(3); ext_in = 0; idle(3); end
      ext_in = 1; idle(12); ext_in = 0; idle(5);
      wr(12'h000, 32'h0);
      rd(12'h004, rv); check("R12 edge ticks", rv, 32'd495);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule